// File: doc/BRIEF.md
# Trace Buffer Capture Controller

This block fills a circular on-chip trace memory with 8-byte trace packets. A producer offers packets on a valid/ready stream. While the capture enable is on, every accepted packet is stored at the current write pointer, and the pointer then advances by 8 bytes. The pointer wraps inside a window whose size software selects. Capture is switched on and off in three ways: by software, by external start and stop levels (each gated by its own enable bit), and by a watermark. A stop caused by the watermark can also raise a halt request toward the debug logic. It then blocks the start level from switching capture back on until software moves the pointer or the watermark, or writes the enable bit to 1.

A single bus port serves both the control registers and the trace memory. The bus data path is 64 bits wide. Register accesses use bits 31:0, and the upper bits read 0. Reads return data one cycle later, with `bus_rvalid` high. A privilege input on the bus controls two things. When the RAM-protect bit is 1, a user access to the memory reads zero and its write is dropped. When the register-protect bit is 1, a user write to a register is dropped. Register reads are never restricted.

Stream rules: `pkt_ready` is low in exactly those cycles in which the bus accesses the trace memory, because both share one memory port. In every other cycle it is high. A packet that is accepted while capture is off is discarded and leaves the pointer unchanged. A producer must keep `pkt_data` stable while `pkt_valid` is high and `pkt_ready` is low.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000_0080 (only register-protect set), pointer and flow registers read 0, and `halt_req_o` is 0.
- R2: With capture on, an accepted packet is stored at memory entry pointer/8, and the pointer register (word 0, bits ADDR_W-1:3, bits 2:0 read 0) advances by 8 on the next cycle.
- R3: With capture off, accepted packets are dropped and the pointer does not move.
- R4: `pkt_ready` is 0 in a cycle with `bus_valid` and `bus_ram` both high and 1 otherwise.
- R5: Control bits 4:0 (wrap field W) limit the pointer to a window of 2^(W+4) bytes: pointer bits at or above position W+4 never change when the pointer advances. A window at least as large as the memory wraps across the whole memory.
- R6: If start-enable (control bit 5) is 1 and `start_in` is high, capture (control bit 31) is on in the next cycle.
- R7: If stop-enable (control bit 6) is 1 and `stop_in` is high, capture is off in the next cycle, even when the start condition is also true.
- R8: With autostop (flow bit 0) set, a packet write that moves the pointer onto the watermark (flow bits ADDR_W-1:3) turns capture off in the next cycle.
- R9: After a watermark stop, the start condition does not re-enable capture until software writes a different pointer or watermark value, or writes control bit 31 as 1. Rewriting the same value keeps the lockout.
- R10: With autohalt (flow bit 1) set, a watermark stop sets the halt bit (control bit 9). `halt_req_o` equals the halt bit ANDed with `dbg_en`.
- R11: With RAM-protect (control bit 8) at 1, a user (`bus_priv`=0) memory read returns 0 and a user memory write is dropped. Privileged accesses, and all accesses while the bit is 0, reach the memory.
- R12: With register-protect (control bit 7) at 1, user register writes are dropped. With it at 0 they take effect.
- R13: Register word 3 and the unused bits of words 0 to 2 read as 0. The word is selected by `bus_addr[3:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | Trace packet offered |
| pkt_ready | output | 1 | Packet can be accepted this cycle |
| pkt_data | input | 64 | Trace packet payload |
| start_in | input | 1 | External start level |
| stop_in | input | 1 | External stop level |
| dbg_en | input | 1 | Invasive debug permitted |
| halt_req_o | output | 1 | Halt request to the debug logic |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_ram | input | 1 | 1 = trace memory, 0 = registers |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |

## Verification
The hardest state to reach from the ports is the watermark lockout while the start level is held high. Reaching it needs wrap-field, watermark and autostop settings that place a packet write exactly on the watermark, with start-enable already set. The stimulus programs a small window, puts the watermark two packets ahead, sends those two packets, and then holds `start_in` high. It first rewrites the watermark with the same value, which must not clear the lockout, and then writes a new pointer, which must. A behavioural model in the bench predicts every output on every cycle throughout this sequence.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int PKT_W = 64;
  localparam int REG_W = 32;

  // register word indices, from bus_addr[3:2]
  localparam logic [1:0] IDX_POS  = 2'd0;
  localparam logic [1:0] IDX_CTRL = 2'd1;
  localparam logic [1:0] IDX_FLOW = 2'd2;

  // control word bit positions
  localparam int B_EN     = 31;
  localparam int B_HALT   = 9;
  localparam int B_RAMP   = 8;
  localparam int B_REGP   = 7;
  localparam int B_STOPEN = 6;
  localparam int B_STRTEN = 5;

  // flow word bit positions
  localparam int B_ASTOP = 0;
  localparam int B_AHALT = 1;

  typedef struct packed {
    logic       en;
    logic       halt;
    logic       ram_prot;
    logic       reg_prot;
    logic       stop_en;
    logic       start_en;
    logic [4:0] wrap;
  } ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_EN]     = c.en;
    v[B_HALT]   = c.halt;
    v[B_RAMP]   = c.ram_prot;
    v[B_REGP]   = c.reg_prot;
    v[B_STOPEN] = c.stop_en;
    v[B_STRTEN] = c.start_en;
    v[4:0]      = c.wrap;
    return v;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] v);
    ctrl_t c;
    c.en       = v[B_EN];
    c.halt     = v[B_HALT];
    c.ram_prot = v[B_RAMP];
    c.reg_prot = v[B_REGP];
    c.stop_en  = v[B_STOPEN];
    c.start_en = v[B_STRTEN];
    c.wrap     = v[4:0];
    return c;
  endfunction
endpackage

// File: rtl/tcc_wrap.sv
module tcc_wrap #(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [4:0]        wrap_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);

  logic [5:0]        lim;
  logic [ADDR_W-1:0] win;
  logic [ADDR_W-1:0] inc;

  assign lim = {1'b0, wrap_i} + 6'd4;

  // each bit below position wrap+4 moves with the increment, the rest hold
  for (genvar i = 0; i < ADDR_W; i++) begin : g_win
    assign win[i] = (6'(i) < lim);
  end

  assign inc   = ptr_i + STEP;
  assign ptr_o = (ptr_i & ~win) | (inc & win);
endmodule

// File: rtl/tcc_ram.sv
module tcc_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                pkt_we,
  input  logic [ADDR_W-4:0]   pkt_idx,
  input  logic [DATA_W-1:0]   pkt_data,
  input  logic                bus_acc,
  input  logic                bus_write,
  input  logic                bus_ok,
  input  logic [ADDR_W-4:0]   bus_idx,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << (ADDR_W - 3);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pkt_we)
      mem[pkt_idx] <= pkt_data;
    else if (bus_acc && bus_write && bus_ok)
      mem[bus_idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (bus_acc && !bus_write && bus_ok)
      rd_data <= mem[bus_idx];
    else
      rd_data <= '0;
  end
endmodule

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [1:0]        sw_idx,
  input  logic [REG_W-1:0]  sw_wdata,
  input  logic              pkt_wr,
  input  logic              start_in,
  input  logic              stop_in,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [REG_W-1:0]  sw_rdata
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_adv, wm_q, wm_d;
  logic              astop_q, astop_d, ahalt_q, ahalt_d;
  logic              lock_q, lock_d;
  logic              wr_pos, wr_ctrl, wr_flow;
  logic [ADDR_W-1:0] sw_addr_val;
  logic              wm_hit, start_go, stop_go, lock_clear;

  tcc_wrap #(.ADDR_W(ADDR_W)) u_wrap (
    .ptr_i (ptr_q),
    .wrap_i(ctrl_q.wrap),
    .ptr_o (ptr_adv)
  );

  assign wr_pos      = sw_we && (sw_idx == IDX_POS);
  assign wr_ctrl     = sw_we && (sw_idx == IDX_CTRL);
  assign wr_flow     = sw_we && (sw_idx == IDX_FLOW);
  assign sw_addr_val = {sw_wdata[ADDR_W-1:3], 3'b000};

  assign wm_hit     = pkt_wr && astop_q && (ptr_adv == wm_q);
  assign start_go   = ctrl_q.start_en && start_in;
  assign stop_go    = ctrl_q.stop_en && stop_in;
  assign lock_clear = (wr_pos && (sw_addr_val != ptr_q)) ||
                      (wr_flow && (sw_addr_val != wm_q)) ||
                      (wr_ctrl && sw_wdata[B_EN]);

  always_comb begin
    ctrl_d  = ctrl_q;
    ptr_d   = ptr_q;
    wm_d    = wm_q;
    astop_d = astop_q;
    ahalt_d = ahalt_q;
    lock_d  = lock_q;

    if (wr_ctrl)
      ctrl_d = ctrl_unpack(sw_wdata);
    else if (start_go && !lock_q)
      ctrl_d.en = 1'b1;

    if (wr_pos)
      ptr_d = sw_addr_val;
    else if (pkt_wr)
      ptr_d = ptr_adv;

    if (wr_flow) begin
      wm_d    = sw_addr_val;
      astop_d = sw_wdata[B_ASTOP];
      ahalt_d = sw_wdata[B_AHALT];
    end

    if (lock_clear)
      lock_d = 1'b0;

    if (wm_hit) begin
      ctrl_d.en = 1'b0;
      lock_d    = 1'b1;
      if (ahalt_q)
        ctrl_d.halt = 1'b1;
    end

    if (stop_go)
      ctrl_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q          <= '0;
      ctrl_q.reg_prot <= 1'b1;
      ptr_q           <= '0;
      wm_q            <= '0;
      astop_q         <= 1'b0;
      ahalt_q         <= 1'b0;
      lock_q          <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      ptr_q   <= ptr_d;
      wm_q    <= wm_d;
      astop_q <= astop_d;
      ahalt_q <= ahalt_d;
      lock_q  <= lock_d;
    end
  end

  always_comb begin
    sw_rdata = '0;
    case (sw_idx)
      IDX_POS:  sw_rdata[ADDR_W-1:3] = ptr_q[ADDR_W-1:3];
      IDX_CTRL: sw_rdata = ctrl_pack(ctrl_q);
      IDX_FLOW: begin
        sw_rdata[ADDR_W-1:3] = wm_q[ADDR_W-1:3];
        sw_rdata[B_ASTOP]    = astop_q;
        sw_rdata[B_AHALT]    = ahalt_q;
      end
      default:  sw_rdata = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign ptr_o  = ptr_q;

  // R7
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go |=> !ctrl_q.en);

  // R8
  wm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wm_hit |=> (!ctrl_q.en && lock_q));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !ctrl_q.en && !lock_clear && !wr_ctrl) |=> !ctrl_q.en);

  // R10
  wm_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_hit && ahalt_q) |=> ctrl_q.halt);

  // R2
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_wr && !wr_pos) |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import tcc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [PKT_W-1:0]  pkt_data,
  input  logic              start_in,
  input  logic              stop_in,
  input  logic              dbg_en,
  output logic              halt_req_o,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_ram,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PKT_W-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [PKT_W-1:0]  bus_rdata
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] ptr;
  logic [REG_W-1:0]  sw_rdata, reg_rd_q;
  logic [PKT_W-1:0]  ram_rd;
  logic              ram_acc, pkt_wr, ram_ok, sw_we;
  logic              rvalid_q, rsel_ram_q;

  assign ram_acc   = bus_valid && bus_ram;
  assign pkt_ready = !ram_acc;
  assign pkt_wr    = pkt_valid && pkt_ready && ctrl.en;
  assign ram_ok    = bus_priv || !ctrl.ram_prot;
  assign sw_we     = bus_valid && bus_write && !bus_ram &&
                     (bus_priv || !ctrl.reg_prot);

  tcc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (sw_we),
    .sw_idx  (bus_addr[3:2]),
    .sw_wdata(bus_wdata[REG_W-1:0]),
    .pkt_wr  (pkt_wr),
    .start_in(start_in),
    .stop_in (stop_in),
    .ctrl_o  (ctrl),
    .ptr_o   (ptr),
    .sw_rdata(sw_rdata)
  );

  tcc_ram #(.ADDR_W(ADDR_W), .DATA_W(PKT_W)) u_ram (
    .clk      (clk),
    .pkt_we   (pkt_wr),
    .pkt_idx  (ptr[ADDR_W-1:3]),
    .pkt_data (pkt_data),
    .bus_acc  (ram_acc),
    .bus_write(bus_write),
    .bus_ok   (ram_ok),
    .bus_idx  (bus_addr[ADDR_W-1:3]),
    .bus_wdata(bus_wdata),
    .rd_data  (ram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      rsel_ram_q <= 1'b0;
      reg_rd_q   <= '0;
    end else begin
      rvalid_q   <= bus_valid && !bus_write;
      rsel_ram_q <= bus_ram;
      reg_rd_q   <= sw_rdata;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rsel_ram_q ? ram_rd : {{(PKT_W-REG_W){1'b0}}, reg_rd_q};
  assign halt_req_o = ctrl.halt && dbg_en;

  // R11
  user_ram_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_acc && !bus_write && !bus_priv && ctrl.ram_prot) |=> (bus_rdata == '0));

  // R3
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !sw_we) |=> (ptr == $past(ptr)));

  // R4
  ready_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |-> ram_acc);
endmodule

// File: tb/tb_trace_capture_ctrl.sv
`timescale 1ns/1ps
module tb_trace_capture_ctrl;
  localparam int AW = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0, start_in = 1'b0, stop_in = 1'b0, dbg_en = 1'b0;
  logic [63:0] pkt_data = '0, bus_wdata = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_ram = 1'b0, bus_priv = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic        pkt_ready, halt_req_o, bus_rvalid;
  logic [63:0] bus_rdata;

  trace_capture_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .start_in(start_in), .stop_in(stop_in), .dbg_en(dbg_en),
    .halt_req_o(halt_req_o), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_ram(bus_ram), .bus_priv(bus_priv), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int  m_ptr, m_wm, m_wrap;
  bit  m_en, m_halt, m_rp, m_sp, m_stopen, m_starten, m_as, m_ah, m_lock;
  logic [63:0] m_mem [int];
  bit  e_rvalid;
  logic [63:0] e_rdata;

  function automatic int ctrl_word();
    return (int'(m_en) << 31) | (int'(m_halt) << 9) | (int'(m_rp) << 8) |
           (int'(m_sp) << 7) | (int'(m_stopen) << 6) | (int'(m_starten) << 5) | m_wrap;
  endfunction

  function automatic int reg_word(input int idx);
    case (idx)
      0: return m_ptr;
      1: return ctrl_word();
      2: return m_wm | (int'(m_ah) << 1) | int'(m_as);
      default: return 0;
    endcase
  endfunction

  function automatic int advance(input int p);
    int lim, win;
    lim = m_wrap + 4;
    win = (lim >= AW) ? ((1 << AW) - 1) : ((1 << lim) - 1);
    return ((p & ~win) | ((p + 8) & win)) & ((1 << AW) - 1);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = 0; m_wm = 0; m_wrap = 0; m_en = 0; m_halt = 0; m_rp = 0; m_sp = 1;
    m_stopen = 0; m_starten = 0; m_as = 0; m_ah = 0; m_lock = 0; e_rvalid = 0;
  endtask

  // one cycle: inputs already driven; compare, clock, update model, compare reads
  task automatic step(input string tag);
    bit ram_acc, fire, wr, swe, wm_hit, lclr;
    int idx, wv, nptr, sv, n_en;
    logic [63:0] rd;
    #1;
    ram_acc = bus_valid && bus_ram;
    check("R4 pkt_ready", {63'b0, pkt_ready}, {63'b0, !ram_acc});
    check("R10 halt_req_o", {63'b0, halt_req_o}, {63'b0, m_halt && dbg_en});
    fire = pkt_valid && !ram_acc;
    wr   = fire && m_en;
    idx  = int'(bus_addr[3:2]);
    wv   = bus_wdata[31:0];
    sv   = wv & ((1 << AW) - 8);
    swe  = bus_valid && bus_write && !bus_ram && (bus_priv || !m_sp);
    rd = 0;
    if (bus_valid && !bus_write) begin
      if (bus_ram) rd = (bus_priv || !m_rp) ? m_mem[int'(bus_addr) >> 3] : 64'd0;
      else rd = {32'b0, 32'(reg_word(idx))};
    end
    nptr = advance(m_ptr);
    wm_hit = wr && m_as && (nptr == m_wm);
    lclr = (swe && idx == 0 && sv != m_ptr) || (swe && idx == 2 && sv != m_wm) ||
           (swe && idx == 1 && wv[31]);
    @(posedge clk);
    if (wr) m_mem[m_ptr >> 3] = pkt_data;
    else if (ram_acc && bus_write && (bus_priv || !m_rp)) m_mem[int'(bus_addr) >> 3] = bus_wdata;
    n_en = m_en;
    if (swe && idx == 1) begin
      n_en = wv[31]; m_halt = wv[9]; m_rp = wv[8]; m_sp = wv[7];
      m_stopen = wv[6]; m_starten = wv[5]; m_wrap = wv & 31;
    end else if (m_starten && start_in && !m_lock) n_en = 1;
    if (swe && idx == 0) m_ptr = sv;
    else if (wr) m_ptr = nptr;
    if (swe && idx == 2) begin m_wm = sv; m_as = wv[0]; m_ah = wv[1]; end
    if (lclr) m_lock = 0;
    if (wm_hit) begin n_en = 0; m_lock = 1; if (m_ah) m_halt = 1; end
    if (m_stopen && stop_in) n_en = 0;
    m_en = n_en[0];
    e_rvalid = bus_valid && !bus_write;
    e_rdata = rd;
    @(negedge clk);
    check({tag, " rvalid"}, {63'b0, bus_rvalid}, {63'b0, e_rvalid});
    if (e_rvalid) check(tag, bus_rdata, e_rdata);
    pkt_valid = 0; bus_valid = 0; bus_write = 0; bus_ram = 0;
  endtask

  task automatic reg_wr(input int idx, input int val, input bit priv, input string tag);
    bus_valid = 1; bus_write = 1; bus_ram = 0; bus_priv = priv;
    bus_addr = AW'(idx << 2); bus_wdata = {32'b0, 32'(val)};
    step(tag);
  endtask

  task automatic reg_rd(input int idx, input bit priv, input string tag);
    bus_valid = 1; bus_write = 0; bus_ram = 0; bus_priv = priv; bus_addr = AW'(idx << 2);
    step(tag);
  endtask

  task automatic ram_acc_t(input int entry, input bit wr, input bit priv,
                           input logic [63:0] d, input string tag);
    bus_valid = 1; bus_write = wr; bus_ram = 1; bus_priv = priv;
    bus_addr = AW'(entry << 3); bus_wdata = d;
    step(tag);
  endtask

  task automatic pkt(input logic [63:0] d, input string tag);
    pkt_valid = 1; pkt_data = d;
    step(tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R13: reset values, unused word
    reg_rd(0, 1, "R1 pointer");
    reg_rd(1, 1, "R1 control");
    reg_rd(2, 1, "R1 flow");
    reg_rd(3, 1, "R13 word3");
    // R12: user write dropped while protected
    reg_wr(1, 32'h8000_0003, 0, "R12 user write");
    reg_rd(1, 0, "R12 ignored");
    // R2: capture, window 64 bytes
    reg_wr(1, 32'h8000_0082, 1, "R2 enable");
    for (int i = 0; i < 3; i++) pkt(64'hA5A5_0000_0000_0000 + 64'(i), "R2 packet");
    reg_rd(0, 1, "R2 pointer");
    for (int i = 0; i < 3; i++) ram_acc_t(i, 0, 1, 0, "R2 stored");
    // R4: packet offered during memory access
    pkt_valid = 1; pkt_data = 64'h1111;
    ram_acc_t(1, 0, 1, 0, "R4 stall");
    pkt(64'h1111, "R4 retry");
    // R5: wrap inside window
    reg_wr(0, 32'h40, 1, "R5 set pointer");
    for (int i = 0; i < 9; i++) pkt(64'h5000 + 64'(i), "R5 packet");
    reg_rd(0, 1, "R5 windowed pointer");
    reg_wr(0, 32'h1F0, 1, "R5 set top");
    reg_wr(1, 32'h8000_009F, 1, "R5 full window");
    for (int i = 0; i < 3; i++) pkt(64'h6000 + 64'(i), "R5 packet full");
    reg_rd(0, 1, "R5 full wrap pointer");
    // R3: capture off
    reg_wr(1, 32'h0000_0082, 1, "R3 disable");
    pkt(64'h7000, "R3 drop"); pkt(64'h7001, "R3 drop");
    reg_rd(0, 1, "R3 pointer held");
    // R6: start
    reg_wr(1, 32'h0000_00A2, 1, "R6 start enable");
    start_in = 1; step("R6 start"); start_in = 0;
    reg_rd(1, 1, "R6 enabled");
    // R7: stop wins
    reg_wr(1, 32'h8000_00E2, 1, "R7 both enables");
    start_in = 1; stop_in = 1; step("R7 both"); start_in = 0; stop_in = 0;
    reg_rd(1, 1, "R7 stopped");
    // R8 R9 R10: watermark
    reg_wr(0, 0, 1, "R8 pointer");
    reg_wr(2, 32'h13, 1, "R8 watermark");
    dbg_en = 1;
    reg_wr(1, 32'h8000_00A2, 1, "R8 enable");
    pkt(64'h8000, "R8 packet"); pkt(64'h8001, "R8 hit");
    reg_rd(1, 1, "R8 R10 stopped halted");
    start_in = 1;
    step("R9 start held"); step("R9 start held");
    reg_rd(1, 1, "R9 still off");
    reg_wr(2, 32'h13, 1, "R9 same watermark");
    reg_rd(1, 1, "R9 lock kept");
    reg_wr(0, 32'h20, 1, "R9 move pointer");
    reg_rd(1, 1, "R9 restarted");
    start_in = 0;
    dbg_en = 0; step("R10 gated");
    // R11: RAM protect
    reg_wr(1, 32'h0000_0182, 1, "R11 protect");
    ram_acc_t(0, 1, 0, 64'hDEAD, "R11 user write");
    ram_acc_t(0, 0, 0, 0, "R11 user read zero");
    ram_acc_t(0, 0, 1, 0, "R11 priv read");
    reg_wr(1, 32'h0000_0082, 1, "R11 unprotect");
    ram_acc_t(0, 1, 0, 64'hBEEF, "R11 user write ok");
    ram_acc_t(0, 0, 0, 0, "R11 user read");
    // R12: unprotected user write
    reg_wr(1, 32'h0000_0002, 1, "R12 open");
    reg_wr(1, 32'h0000_0005, 0, "R12 user write");
    reg_rd(1, 0, "R12 applied");
    reg_rd(2, 0, "R13 flow unused bits");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule